// File: doc/BRIEF.md
# Hotplug Event Register Block

This block keeps the state that firmware uses to learn about processor and PCI slot hot-add and hot-remove. It holds a 16-bit event status register and a 16-bit event enable register, both byte-addressable. It also holds a pair of processor bitmaps, one for arrivals and one for departures, and a matching pair of slot bitmaps. Host software reads and writes all of these through a small register port.

Two event inputs come from the platform, one for processors and one for slots. An accepted event first wipes the pair of bitmaps for its class. It then marks exactly one bit: the arrival bitmap for an add, or the departure bitmap for a remove. It also raises the class bit in both the status and enable registers and sends a single-cycle pulse on the system control interrupt line. An eject port takes a slot mask from software and emits a removal strobe carrying the index of the lowest set bit.

The register port has no back-pressure: the block accepts a request in every cycle that `acc_valid` is high, and a read returns its data with `rd_valid` one cycle later. The event inputs are also accepted on every cycle they are valid. Registers live at these byte offsets: status bytes 0x00 (bits 7:0) and 0x01 (bits 15:8); enable bytes 0x02 (bits 7:0) and 0x03 (bits 15:8); processor arrivals 0x04; processor departures 0x05; slot arrivals 0x08; slot departures 0x0C; eject 0x10. Byte registers take and return `acc_wdata[7:0]`, zero-extended on read.

Top module: `hp_gpe_top`

## Requirements
- R1: After reset, every register reads zero, `sci` is low and `eject_valid` is low.
- R2: A write to one of offsets 0x00..0x03 changes only that byte of the status or enable register, and a later read returns it.
- R3: Processor arrival (0x04) and departure (0x05) bitmaps are writable and read back their last written byte.
- R4: Slot arrival (0x08) and departure (0x0C) bitmaps are writable as full 32-bit words and read back.
- R5: An accepted processor event clears both processor bitmaps and sets bit `cpu_evt_id` of the arrival bitmap (add=1) or the departure bitmap (add=0). It also sets status bit 0 and enable bit 0 and leaves the other status and enable bits unchanged.
- R6: An accepted slot event clears both slot bitmaps and sets bit `pci_evt_slot` of the arrival bitmap (add=1) or the departure bitmap (add=0). It also sets status bit 1 and enable bit 1 and leaves the other bits unchanged.
- R7: `sci` is high for exactly the cycle after any cycle in which at least one event is accepted, and low otherwise. Two events in the same cycle give a single pulse.
- R8: A nonzero write to 0x10 makes `eject_valid` high for the following cycle, with `eject_slot` equal to the index of the lowest set bit of the written word.
- R9: A zero write to 0x10 produces no strobe, and a read of 0x10 returns zero.
- R10: Reads of unmapped offsets return zero, and writes to them change no register.
- R11: When a host write and an event hit the same register in the same cycle, the event is applied after the write. Event bits are ORed over the written status or enable byte, and the event's bitmap pattern replaces the written bitmap.
- R12: Every read request gives `rd_valid` high exactly one cycle later, with the register value from before that edge. Writes give no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Register request present |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte offset of the register |
| acc_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid (one cycle after request) |
| rd_data | output | 32 | Read data |
| cpu_evt_valid | input | 1 | Processor event strobe |
| cpu_evt_add | input | 1 | 1 = processor added, 0 = removed |
| cpu_evt_id | input | CPU_IDW | Processor index |
| pci_evt_valid | input | 1 | Slot event strobe |
| pci_evt_add | input | 1 | 1 = slot added, 0 = removed |
| pci_evt_slot | input | SLOT_IDW | Slot index |
| sci | output | 1 | Interrupt pulse |
| eject_valid | output | 1 | Slot removal strobe |
| eject_slot | output | SLOT_IDW | Slot index to remove |

## Verification
Directed cases write each status and enable byte on its own, so a byte-lane mix-up shows in the untouched byte. Processor and slot events are sent with indices at both ends of their range, in add and remove form, and after bitmaps have been filled with ones; this separates a "clear then set" update from a plain OR. The eject port receives single-bit, multi-bit, all-ones and zero words. These tell the lowest-set-bit encoding apart from a highest-bit or plain binary one, and they confirm that zero gives no strobe. Random traffic mixes reads, writes to mapped and unmapped offsets, and events that collide with writes in the same cycle, all compared against a bench model.

// File: rtl/hp_gpe_pkg.sv
package hp_gpe_pkg;
  localparam int EVT_W     = 16;
  localparam int EVT_NB    = EVT_W / 8;
  localparam int OFF_CPU_UP = 4;
  localparam int OFF_CPU_DN = 5;
  localparam int OFF_PCI_UP = 8;
  localparam int OFF_PCI_DN = 12;
  localparam int OFF_EJECT  = 16;
  localparam int CLS_CPU    = 0;
  localparam int CLS_PCI    = 1;
endpackage

// File: rtl/hp_evt_regs.sv
module hp_evt_regs
  import hp_gpe_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       byte_idx,
  input  logic [7:0]       wdata,
  input  logic [EVT_W-1:0] set_mask,
  output logic [EVT_W-1:0] sts,
  output logic [EVT_W-1:0] en
);
  for (genvar b = 0; b < EVT_NB; b++) begin : g_byte
    logic [7:0] sts_nxt, en_nxt;
    always_comb begin
      sts_nxt = (wr_en && byte_idx == 3'(b)) ? wdata : sts[b*8 +: 8];
      en_nxt  = (wr_en && byte_idx == 3'(b + EVT_NB)) ? wdata : en[b*8 +: 8];
    end
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sts[b*8 +: 8] <= '0;
        en[b*8 +: 8]  <= '0;
      end else begin
        sts[b*8 +: 8] <= sts_nxt | set_mask[b*8 +: 8];
        en[b*8 +: 8]  <= en_nxt | set_mask[b*8 +: 8];
      end
    end
  end
endmodule

// File: rtl/hp_bitmap.sv
module hp_bitmap #(
  parameter int W   = 8,
  localparam int IDW = $clog2(W)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_up,
  input  logic           wr_dn,
  input  logic [W-1:0]   wdata,
  input  logic           evt_valid,
  input  logic           evt_add,
  input  logic [IDW-1:0] evt_idx,
  output logic [W-1:0]   up,
  output logic [W-1:0]   dn
);
  logic [W-1:0] onehot;
  assign onehot = W'(1) << evt_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      up <= '0;
      dn <= '0;
    end else if (evt_valid) begin
      up <= evt_add ? onehot : '0;
      dn <= evt_add ? '0 : onehot;
    end else begin
      if (wr_up) up <= wdata;
      if (wr_dn) dn <= wdata;
    end
  end
endmodule

// File: rtl/hp_eject.sv
module hp_eject #(
  parameter int SLOT_W = 32,
  localparam int IDW = $clog2(SLOT_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [SLOT_W-1:0] mask,
  output logic              eject_valid,
  output logic [IDW-1:0]    eject_slot
);
  logic [IDW-1:0] low_idx;
  always_comb begin
    low_idx = '0;
    for (int i = SLOT_W - 1; i >= 0; i--)
      if (mask[i]) low_idx = IDW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eject_valid <= 1'b0;
      eject_slot  <= '0;
    end else begin
      eject_valid <= wr && (mask != '0);
      if (wr && (mask != '0)) eject_slot <= low_idx;
    end
  end
endmodule

// File: rtl/hp_gpe_top.sv
module hp_gpe_top
  import hp_gpe_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int CPU_W  = 8,
  parameter int SLOT_W = 32,
  localparam int CPU_IDW  = $clog2(CPU_W),
  localparam int SLOT_IDW = $clog2(SLOT_W)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc_valid,
  input  logic                acc_write,
  input  logic [ADDR_W-1:0]   acc_addr,
  input  logic [31:0]         acc_wdata,
  output logic                rd_valid,
  output logic [31:0]         rd_data,
  input  logic                cpu_evt_valid,
  input  logic                cpu_evt_add,
  input  logic [CPU_IDW-1:0]  cpu_evt_id,
  input  logic                pci_evt_valid,
  input  logic                pci_evt_add,
  input  logic [SLOT_IDW-1:0] pci_evt_slot,
  output logic                sci,
  output logic                eject_valid,
  output logic [SLOT_IDW-1:0] eject_slot
);
  logic              wr, rd;
  logic              hit_evt;
  logic [EVT_W-1:0]  evt_sts, evt_en, set_mask;
  logic [CPU_W-1:0]  cpu_up, cpu_dn;
  logic [SLOT_W-1:0] pci_up, pci_dn;

  assign wr      = acc_valid && acc_write;
  assign rd      = acc_valid && !acc_write;
  assign hit_evt = acc_addr < ADDR_W'(2 * EVT_NB);

  always_comb begin
    set_mask = '0;
    set_mask[CLS_CPU] = cpu_evt_valid;
    set_mask[CLS_PCI] = pci_evt_valid;
  end

  hp_evt_regs u_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr && hit_evt),
    .byte_idx (3'(acc_addr)),
    .wdata    (acc_wdata[7:0]),
    .set_mask (set_mask),
    .sts      (evt_sts),
    .en       (evt_en)
  );

  hp_bitmap #(.W(CPU_W)) u_cpu (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_up     (wr && acc_addr == ADDR_W'(OFF_CPU_UP)),
    .wr_dn     (wr && acc_addr == ADDR_W'(OFF_CPU_DN)),
    .wdata     (acc_wdata[CPU_W-1:0]),
    .evt_valid (cpu_evt_valid),
    .evt_add   (cpu_evt_add),
    .evt_idx   (cpu_evt_id),
    .up        (cpu_up),
    .dn        (cpu_dn)
  );

  hp_bitmap #(.W(SLOT_W)) u_pci (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_up     (wr && acc_addr == ADDR_W'(OFF_PCI_UP)),
    .wr_dn     (wr && acc_addr == ADDR_W'(OFF_PCI_DN)),
    .wdata     (acc_wdata[SLOT_W-1:0]),
    .evt_valid (pci_evt_valid),
    .evt_add   (pci_evt_add),
    .evt_idx   (pci_evt_slot),
    .up        (pci_up),
    .dn        (pci_dn)
  );

  hp_eject #(.SLOT_W(SLOT_W)) u_ej (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr          (wr && acc_addr == ADDR_W'(OFF_EJECT)),
    .mask        (acc_wdata[SLOT_W-1:0]),
    .eject_valid (eject_valid),
    .eject_slot  (eject_slot)
  );

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (hit_evt) begin
      for (int b = 0; b < EVT_NB; b++) begin
        if (acc_addr == ADDR_W'(b))          rd_mux[7:0] = evt_sts[b*8 +: 8];
        if (acc_addr == ADDR_W'(b + EVT_NB)) rd_mux[7:0] = evt_en[b*8 +: 8];
      end
    end else if (acc_addr == ADDR_W'(OFF_CPU_UP)) rd_mux[CPU_W-1:0]  = cpu_up;
    else if (acc_addr == ADDR_W'(OFF_CPU_DN))     rd_mux[CPU_W-1:0]  = cpu_dn;
    else if (acc_addr == ADDR_W'(OFF_PCI_UP))     rd_mux[SLOT_W-1:0] = pci_up;
    else if (acc_addr == ADDR_W'(OFF_PCI_DN))     rd_mux[SLOT_W-1:0] = pci_dn;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      sci      <= 1'b0;
    end else begin
      rd_valid <= rd;
      if (rd) rd_data <= rd_mux;
      sci <= cpu_evt_valid || pci_evt_valid;
    end
  end
endmodule

// File: rtl/hp_gpe_chk.sv
module hp_gpe_chk #(
  parameter int ADDR_W = 5,
  parameter int CPU_W  = 8,
  parameter int SLOT_W = 32,
  parameter int EVT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic              acc_write,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [31:0]       acc_wdata,
  input logic              rd_valid,
  input logic              cpu_evt_valid,
  input logic              pci_evt_valid,
  input logic              sci,
  input logic              eject_valid,
  input logic [EVT_W-1:0]  evt_sts,
  input logic [EVT_W-1:0]  evt_en,
  input logic [CPU_W-1:0]  cpu_up,
  input logic [CPU_W-1:0]  cpu_dn,
  input logic [SLOT_W-1:0] pci_up,
  input logic [SLOT_W-1:0] pci_dn
);
  logic ej_wr;
  assign ej_wr = acc_valid && acc_write && acc_addr == ADDR_W'(16);

  p_cpu_class_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_evt_valid |=> evt_sts[0] && evt_en[0]);
  p_cpu_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_evt_valid |=> $countones({cpu_up, cpu_dn}) == 1);
  p_pci_class_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pci_evt_valid |=> evt_sts[1] && evt_en[1]);
  p_pci_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pci_evt_valid |=> $countones({pci_up, pci_dn}) == 1);
  p_sci_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_evt_valid || pci_evt_valid) |=> sci);
  p_sci_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_evt_valid || pci_evt_valid) |=> !sci);
  p_eject_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    eject_valid |-> $past(ej_wr));
  p_eject_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ej_wr && acc_wdata[SLOT_W-1:0] == '0) |=> !eject_valid);
  p_rd_resp_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write) |=> rd_valid);
  p_rd_only_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && !acc_write) |=> !rd_valid);
endmodule

bind hp_gpe_top hp_gpe_chk #(
  .ADDR_W(ADDR_W), .CPU_W(CPU_W), .SLOT_W(SLOT_W), .EVT_W(hp_gpe_pkg::EVT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rd_valid(rd_valid),
  .cpu_evt_valid(cpu_evt_valid), .pci_evt_valid(pci_evt_valid), .sci(sci),
  .eject_valid(eject_valid), .evt_sts(evt_sts), .evt_en(evt_en),
  .cpu_up(cpu_up), .cpu_dn(cpu_dn), .pci_up(pci_up), .pci_dn(pci_dn)
);

// File: tb/tb_hp_gpe_top.sv
module tb_hp_gpe_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        acc_valid = 0, acc_write = 0;
  logic [4:0]  acc_addr = 0;
  logic [31:0] acc_wdata = 0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        cpu_evt_valid = 0, cpu_evt_add = 0;
  logic [2:0]  cpu_evt_id = 0;
  logic        pci_evt_valid = 0, pci_evt_add = 0;
  logic [4:0]  pci_evt_slot = 0;
  logic        sci, eject_valid;
  logic [4:0]  eject_slot;

  always #10 clk = ~clk;

  hp_gpe_top dut (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  string tag = "";

  logic [15:0] m_sts = 0, m_en = 0;
  logic [7:0]  m_cup = 0, m_cdn = 0;
  logic [31:0] m_pup = 0, m_pdn = 0;

  function automatic logic [31:0] model_rd(input logic [4:0] a);
    case (a)
      5'd0: return {24'd0, m_sts[7:0]};
      5'd1: return {24'd0, m_sts[15:8]};
      5'd2: return {24'd0, m_en[7:0]};
      5'd3: return {24'd0, m_en[15:8]};
      5'd4: return {24'd0, m_cup};
      5'd5: return {24'd0, m_cdn};
      5'd8: return m_pup;
      5'd12: return m_pdn;
      default: return 32'd0;
    endcase
  endfunction

  function automatic int lowest_bit(input logic [31:0] v);
    for (int i = 0; i < 32; i++) if (v[i]) return i;
    return 0;
  endfunction

  function automatic string rd_tag(input logic [4:0] a);
    if (a < 4) return "R2";
    if (a == 4 || a == 5) return "R3";
    if (a == 8 || a == 12) return "R4";
    if (a == 16) return "R9";
    return "R10";
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", (tag != "") ? tag : req, act, exp);
    end
  endtask

  task automatic step(input bit av, input bit aw, input logic [4:0] ad, input logic [31:0] wd,
                      input bit cv, input bit ca, input logic [2:0] ci,
                      input bit pv, input bit pa, input logic [4:0] ps);
    logic [31:0] e_rd;
    bit e_ej;
    int e_slot;
    @(negedge clk);
    acc_valid = av; acc_write = aw; acc_addr = ad; acc_wdata = wd;
    cpu_evt_valid = cv; cpu_evt_add = ca; cpu_evt_id = ci;
    pci_evt_valid = pv; pci_evt_add = pa; pci_evt_slot = ps;
    e_rd   = model_rd(ad);
    e_ej   = av && aw && ad == 16 && wd != 0;
    e_slot = lowest_bit(wd);
    @(posedge clk); #1;
    check("R7", {31'd0, sci}, {31'd0, cv || pv});
    check((av && aw && ad == 16 && wd == 0) ? "R9" : "R8", {31'd0, eject_valid}, {31'd0, e_ej});
    if (e_ej) check("R8", {27'd0, eject_slot}, e_slot[31:0]);
    check("R12", {31'd0, rd_valid}, {31'd0, av && !aw});
    if (av && !aw) check(rd_tag(ad), rd_data, e_rd);
    // model update: host write, then events on top (R11)
    if (av && aw) begin
      case (ad)
        5'd0: m_sts[7:0] = wd[7:0];
        5'd1: m_sts[15:8] = wd[7:0];
        5'd2: m_en[7:0] = wd[7:0];
        5'd3: m_en[15:8] = wd[7:0];
        5'd4: m_cup = wd[7:0];
        5'd5: m_cdn = wd[7:0];
        5'd8: m_pup = wd;
        5'd12: m_pdn = wd;
        default: ;
      endcase
    end
    if (cv) begin
      m_cup = ca ? (8'd1 << ci) : 8'd0;
      m_cdn = ca ? 8'd0 : (8'd1 << ci);
      m_sts[0] = 1'b1; m_en[0] = 1'b1;
    end
    if (pv) begin
      m_pup = pa ? (32'd1 << ps) : 32'd0;
      m_pdn = pa ? 32'd0 : (32'd1 << ps);
      m_sts[1] = 1'b1; m_en[1] = 1'b1;
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    step(1, 1, a, d, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic rd(input logic [4:0] a);
    step(1, 0, a, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic read_all();
    for (int a = 0; a < 32; a++) rd(5'(a));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    tag = "R1"; read_all();
    // R2 byte lanes
    tag = "R2";
    wr(0, 32'hA5); wr(3, 32'h3C); rd(0); rd(1); rd(2); rd(3);
    wr(1, 32'hFF); wr(2, 32'h81); rd(0); rd(1); rd(2); rd(3);
    tag = "R3"; wr(4, 32'hFFFF_FF5A); wr(5, 32'hC3); rd(4); rd(5);
    tag = "R4"; wr(8, 32'hDEAD_BEEF); wr(12, 32'h1234_5678); rd(8); rd(12);
    // R5 processor events after bitmaps full
    tag = "R5";
    wr(4, 32'hFF); wr(5, 32'hFF); wr(0, 0); wr(2, 0);
    step(0, 0, 0, 0, 1, 1, 7, 0, 0, 0); rd(4); rd(5); rd(0); rd(2);
    step(0, 0, 0, 0, 1, 0, 0, 0, 0, 0); rd(4); rd(5);
    // R6 slot events
    tag = "R6";
    wr(8, 32'hFFFF_FFFF); wr(12, 32'hFFFF_FFFF);
    step(0, 0, 0, 0, 0, 0, 0, 1, 1, 31); rd(8); rd(12); rd(0); rd(2);
    step(0, 0, 0, 0, 0, 0, 0, 1, 0, 0); rd(8); rd(12);
    // R7 both events one cycle, then back to back
    tag = "R7";
    step(0, 0, 0, 0, 1, 1, 3, 1, 1, 9);
    step(0, 0, 0, 0, 1, 0, 2, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R8 / R9 eject
    tag = "R8";
    wr(16, 32'h8000_0000); wr(16, 32'h0000_0006); wr(16, 32'hFFFF_FFFF); wr(16, 32'h0001_0000);
    tag = "R9"; wr(16, 0); rd(16); wr(16, 0);
    // R10 unmapped
    tag = "R10";
    wr(6, 32'hFF); wr(9, 32'hFF); wr(20, 32'hFFFF_FFFF); wr(31, 32'hFF);
    read_all();
    // R11 collisions
    tag = "R11";
    step(1, 1, 0, 32'h00, 1, 1, 1, 0, 0, 0); rd(0);
    step(1, 1, 4, 32'hF0, 1, 0, 6, 0, 0, 0); rd(4); rd(5);
    step(1, 1, 12, 32'hFFFF_0000, 0, 0, 0, 1, 1, 4); rd(8); rd(12);
    step(1, 1, 2, 32'h00, 0, 0, 0, 1, 0, 5); rd(2);
    // random traffic
    tag = "";
    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      logic [4:0] a;
      logic [31:0] d;
      int sel;
      sel = $urandom_range(0, 9);
      a = (sel < 7) ? 5'($urandom_range(0, 4) * 4 + $urandom_range(0, 1)) : 5'($urandom);
      d = ($urandom_range(0, 3) == 0) ? (32'd1 << $urandom_range(0, 31)) : $urandom;
      step($urandom_range(0, 3) != 0, $urandom_range(0, 1), a, d,
           $urandom_range(0, 5) == 0, $urandom_range(0, 1), 3'($urandom),
           $urandom_range(0, 5) == 0, $urandom_range(0, 1), 5'($urandom));
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule